// File: doc/BRIEF.md
# Receive Frame Count Threshold Interrupt

This block keeps a running tally of complete frames sitting in a receive queue and raises a receive interrupt status bit when the host should come and drain them. The receive path pulses `frame_done_i` each time a whole frame has been stored. The host side pulses `frame_free_i` each time it releases a frame.

When `thr_mode_i` is high, the interrupt sets only once the number of waiting frames rises above a host-programmed threshold. When it is low, every stored frame sets the interrupt. The host sees one 16-bit register. The high byte is a read-only copy of the frame count, taken at the moment the interrupt was last raised. The low byte is the read/write threshold. The host clears the status bit by pulsing `irq_clr_i`, which stands for writing 1 to it.

All pins are plain event or level signals. Each pulse is one clock wide and is taken in the cycle it is high. Nothing is queued and there is no back-pressure: the frame source and the host never wait on this block. Every effect of an input is visible on the outputs right after the clock edge that samples it.

Top module: `rxthr_irq`

## Requirements
- R1: After reset, `reg_rdata_o` reads 0x0000 and `irq_o` is 0.
- R2: The internal frame count goes up by one on `frame_done_i` and down by one on `frame_free_i`. When both pulse in the same cycle, the count is unchanged.
- R3: The frame count saturates at 255 and never goes below 0. Extra pulses at either limit leave it unchanged.
- R4: A cycle with `thr_wr_i` high loads `thr_wdata_i` into `reg_rdata_o[7:0]`, and that write leaves `reg_rdata_o[15:8]` and `irq_o` unchanged. Without a write, the threshold holds.
- R5: With `thr_mode_i` = 1, a `frame_done_i` cycle sets `irq_o` if the count after that cycle is strictly greater than the threshold. The interrupt therefore first sets at count = threshold + 1. Below that point, `irq_o` and the count byte stay unchanged.
- R6: With `thr_mode_i` = 0, every `frame_done_i` cycle sets `irq_o`.
- R7: `irq_clr_i` clears `irq_o` on the next edge. If a set event happens in the same cycle, the set wins and `irq_o` stays 1.
- R8: On each set event, `reg_rdata_o[15:8]` takes the count as updated by that cycle. Between set events it holds, even as the count changes.
- R9: After a clear, if the threshold condition still holds, the next `frame_done_i` sets `irq_o` again.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low synchronous reset |
| frame_done_i | input | 1 | One-cycle pulse: a complete frame was stored |
| frame_free_i | input | 1 | One-cycle pulse: the host released a frame |
| thr_mode_i | input | 1 | 1 = threshold mode, 0 = interrupt on every frame |
| thr_wr_i | input | 1 | Write strobe for the threshold byte |
| thr_wdata_i | input | 8 | New threshold value |
| irq_clr_i | input | 1 | Write-1-to-clear pulse for the status bit |
| reg_rdata_o | output | 16 | {captured count, threshold} |
| irq_o | output | 1 | Receive interrupt status |

## Verification
Directed runs step the count across the threshold one frame at a time. These show whether the compare is strict and whether the count byte moves only when the interrupt fires. Clear-then-frame and clear-with-frame sequences tell a sticky re-arm apart from a one-shot, and also show which of set and clear has priority. Long runs of one pulse type drive the count into both limits, so wrap-around shows up in the captured byte. Seeded random mixes of store, release, clear, write and mode toggles follow, checked every cycle against a bench model; these catch the simultaneous store-and-release case and any mode-switch corner.

// File: rtl/rxthr_pkg.sv
package rxthr_pkg;
  typedef enum logic [1:0] {
    CNT_HOLD = 2'd0,
    CNT_UP   = 2'd1,
    CNT_DOWN = 2'd2
  } cnt_op_e;

  function automatic cnt_op_e op_decode(input logic up, input logic down);
    if (up && !down)      return CNT_UP;
    else if (down && !up) return CNT_DOWN;
    else                  return CNT_HOLD;
  endfunction
endpackage

// File: rtl/rxthr_counter.sv
module rxthr_counter
  import rxthr_pkg::*;
#(
  parameter int W = 8
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  cnt_op_e      op_i,
  output logic [W-1:0] cnt_nxt_o
);
  localparam logic [W-1:0] CNT_MAX = {W{1'b1}};
  localparam logic [W-1:0] CNT_MIN = '0;

  logic [W-1:0] cnt_q;

  always_comb begin
    cnt_nxt_o = cnt_q;
    unique case (op_i)
      CNT_UP:   if (cnt_q != CNT_MAX) cnt_nxt_o = cnt_q + 1'b1;
      CNT_DOWN: if (cnt_q != CNT_MIN) cnt_nxt_o = cnt_q - 1'b1;
      default:  cnt_nxt_o = cnt_q;
    endcase
  end

  always_ff @(posedge clk_i) begin
    if (!rst_ni) cnt_q <= '0;
    else         cnt_q <= cnt_nxt_o;
  end
endmodule

// File: rtl/rxthr_trigger.sv
module rxthr_trigger #(
  parameter int W = 8
) (
  input  logic         frame_done_i,
  input  logic         thr_mode_i,
  input  logic [W-1:0] cnt_nxt_i,
  input  logic [W-1:0] thr_i,
  output logic         set_evt_o
);
  logic above;

  always_comb begin
    above     = (cnt_nxt_i > thr_i);
    set_evt_o = frame_done_i && (!thr_mode_i || above);
  end
endmodule

// File: rtl/rxthr_status.sv
module rxthr_status #(
  parameter int W = 8
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic         set_evt_i,
  input  logic         clr_i,
  input  logic [W-1:0] cnt_nxt_i,
  output logic         irq_o,
  output logic [W-1:0] snap_o
);
  always_ff @(posedge clk_i) begin
    if (!rst_ni) begin
      irq_o  <= 1'b0;
      snap_o <= '0;
    end else begin
      if (set_evt_i) begin
        irq_o  <= 1'b1;
        snap_o <= cnt_nxt_i;
      end else if (clr_i) begin
        irq_o  <= 1'b0;
      end
    end
  end
endmodule

// File: rtl/rxthr_irq.sv
module rxthr_irq
  import rxthr_pkg::*;
#(
  parameter int CNT_W = 8
) (
  input  logic               clk_i,
  input  logic               rst_ni,
  input  logic               frame_done_i,
  input  logic               frame_free_i,
  input  logic               thr_mode_i,
  input  logic               thr_wr_i,
  input  logic [CNT_W-1:0]   thr_wdata_i,
  input  logic               irq_clr_i,
  output logic [2*CNT_W-1:0] reg_rdata_o,
  output logic               irq_o
);
  localparam int REG_W = 2 * CNT_W;

  cnt_op_e          op;
  logic [CNT_W-1:0] cnt_nxt;
  logic [CNT_W-1:0] thr_q;
  logic [CNT_W-1:0] snap;
  logic             set_evt;

  assign op = op_decode(frame_done_i, frame_free_i);

  rxthr_counter #(.W(CNT_W)) u_cnt (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .op_i      (op),
    .cnt_nxt_o (cnt_nxt)
  );

  always_ff @(posedge clk_i) begin
    if (!rst_ni)       thr_q <= '0;
    else if (thr_wr_i) thr_q <= thr_wdata_i;
  end

  rxthr_trigger #(.W(CNT_W)) u_trig (
    .frame_done_i (frame_done_i),
    .thr_mode_i   (thr_mode_i),
    .cnt_nxt_i    (cnt_nxt),
    .thr_i        (thr_q),
    .set_evt_o    (set_evt)
  );

  rxthr_status #(.W(CNT_W)) u_stat (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .set_evt_i (set_evt),
    .clr_i     (irq_clr_i),
    .cnt_nxt_i (cnt_nxt),
    .irq_o     (irq_o),
    .snap_o    (snap)
  );

  assign reg_rdata_o = REG_W'({snap, thr_q});
endmodule

// File: rtl/rxthr_irq_chk.sv
module rxthr_irq_chk #(
  parameter int CNT_W = 8
) (
  input logic               clk_i,
  input logic               rst_ni,
  input logic               frame_done_i,
  input logic               thr_mode_i,
  input logic               thr_wr_i,
  input logic               irq_clr_i,
  input logic [2*CNT_W-1:0] reg_rdata_o,
  input logic               irq_o
);
  // R5
  irq_rise_needs_frame_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(irq_o) |-> $past(frame_done_i));

  // R6
  every_frame_sets_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (frame_done_i && !thr_mode_i) |=> irq_o);

  // R7
  clear_wins_alone_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (irq_clr_i && !frame_done_i) |=> !irq_o);

  // R4
  thr_holds_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !thr_wr_i |=> $stable(reg_rdata_o[CNT_W-1:0]));

  // R8
  snap_holds_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !frame_done_i |=> $stable(reg_rdata_o[2*CNT_W-1:CNT_W]));
endmodule

bind rxthr_irq rxthr_irq_chk #(.CNT_W(CNT_W)) u_chk (
  .clk_i        (clk_i),
  .rst_ni       (rst_ni),
  .frame_done_i (frame_done_i),
  .thr_mode_i   (thr_mode_i),
  .thr_wr_i     (thr_wr_i),
  .irq_clr_i    (irq_clr_i),
  .reg_rdata_o  (reg_rdata_o),
  .irq_o        (irq_o)
);

// File: tb/rxthr_irq_tb_top.sv
module rxthr_irq_tb_top;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        done_p = 1'b0, free_p = 1'b0, mode = 1'b0, wr = 1'b0, clr = 1'b0;
  logic [7:0]  wdata = '0;
  logic [15:0] rdata;
  logic        irq;

  int checks = 0;
  int errors = 0;
  bit finished = 0;

  int         m_cnt = 0;
  logic [7:0] m_thr = '0;
  logic [7:0] m_snap = '0;
  logic       m_irq = 1'b0;

  always #5 clk = ~clk;

  rxthr_irq dut_i (
    .clk_i        (clk),
    .rst_ni       (rst_n),
    .frame_done_i (done_p),
    .frame_free_i (free_p),
    .thr_mode_i   (mode),
    .thr_wr_i     (wr),
    .thr_wdata_i  (wdata),
    .irq_clr_i    (clr),
    .reg_rdata_o  (rdata),
    .irq_o        (irq)
  );

  function automatic int next_cnt(int c, logic up, logic dn);
    if (up && !dn) return (c < 255) ? c + 1 : c;
    if (dn && !up) return (c > 0) ? c - 1 : c;
    return c;
  endfunction

  function automatic logic sets(logic up, logic md, int nc, logic [7:0] t);
    return up && (!md || nc > int'(t));
  endfunction

  task automatic check(string tag, logic [31:0] act, logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual 0x%0h expected 0x%0h", tag, act, exp);
    end
  endtask

  task automatic finish_run();
    if (!finished) begin
      finished = 1;
      $display("  Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  endtask

  // Apply one cycle of stimulus (called just after a negedge) and compare after the edge.
  task automatic step(string tag, logic up, logic dn, logic md, logic c,
                      logic w, logic [7:0] wd);
    int nc;
    logic s;
    done_p = up; free_p = dn; mode = md; clr = c; wr = w; wdata = wd;
    nc = next_cnt(m_cnt, up, dn);
    s  = sets(up, md, nc, m_thr);
    @(posedge clk);
    m_cnt = nc;
    if (s) begin
      m_irq  = 1'b1;
      m_snap = 8'(nc);
    end else if (c) begin
      m_irq = 1'b0;
    end
    if (w) m_thr = wd;
    #2;
    check({tag, " reg"}, 32'(rdata), 32'({m_snap, m_thr}));
    check({tag, " irq"}, 32'(irq), 32'(m_irq));
    @(negedge clk);
    done_p = 0; free_p = 0; clr = 0; wr = 0;
  endtask

  initial begin
    #(200000 * 10);
    errors++;
    $display("FAIL watchdog: actual timeout expected completion");
    finish_run();
  end

  initial begin
    repeat (3) @(negedge clk);
    // R1 reset state
    check("R1 reg", 32'(rdata), 32'h0);
    check("R1 irq", 32'(irq), 32'h0);
    rst_n = 1'b1;
    @(negedge clk);

    // R4 threshold write, count byte and irq untouched
    step("R4", 0, 0, 1, 0, 1, 8'd2);
    check("R4 low byte", 32'(rdata[7:0]), 32'd2);
    check("R4 high byte", 32'(rdata[15:8]), 32'd0);

    // R5 strict compare: threshold 2, interrupt at count 3
    step("R5 c1", 1, 0, 1, 0, 0, 0);
    step("R5 c2", 1, 0, 1, 0, 0, 0);
    check("R5 below thr irq", 32'(irq), 32'd0);
    step("R5 c3", 1, 0, 1, 0, 0, 0);
    check("R5 thr+1 irq", 32'(irq), 32'd1);
    check("R8 snap at set", 32'(rdata[15:8]), 32'd3);

    // R2 both pulses hold the count; R8 snap holds across releases
    step("R2 both", 1, 1, 1, 0, 0, 0);
    step("R8 release", 0, 1, 1, 0, 0, 0);
    check("R8 snap held", 32'(rdata[15:8]), 32'd3);

    // R7 clear alone, then clear with set
    step("R7 clr", 0, 0, 1, 1, 0, 0);
    check("R7 cleared", 32'(irq), 32'd0);
    step("R7 clr+set", 1, 0, 1, 1, 0, 0);
    check("R7 set wins", 32'(irq), 32'd1);
    check("R2 count via snap", 32'(rdata[15:8]), 32'd3);

    // R9 re-set after clear when still above threshold
    step("R9 clr", 0, 0, 1, 1, 0, 0);
    step("R9 next", 1, 0, 1, 0, 0, 0);
    check("R9 re-set", 32'(irq), 32'd1);
    check("R9 snap", 32'(rdata[15:8]), 32'd4);

    // R6 every frame sets with threshold mode off, even below threshold
    step("R6 thr", 0, 0, 0, 1, 1, 8'd200);
    step("R6 frame", 1, 0, 0, 0, 0, 0);
    check("R6 irq", 32'(irq), 32'd1);

    // R3 saturation at 255
    for (int i = 0; i < 260; i++) step("R3 up", 1, 0, 0, 0, 0, 0);
    check("R3 sat high", 32'(rdata[15:8]), 32'd255);
    // R3 floor at 0
    for (int i = 0; i < 300; i++) step("R3 down", 0, 1, 0, 0, 0, 0);
    step("R3 after floor", 1, 0, 0, 0, 0, 0);
    check("R3 floor", 32'(rdata[15:8]), 32'd1);

    // Random mix with fixed seed
    void'($urandom(32'd4242));
    for (int i = 0; i < 4000; i++) begin
      logic up, dn, md, c, w;
      logic [7:0] wd;
      up = ($urandom % 100) < 50;
      dn = ($urandom % 100) < 35;
      md = ($urandom % 100) < 80;
      c  = ($urandom % 100) < 15;
      w  = ($urandom % 100) < 4;
      wd = 8'($urandom % 24);
      step("R2/R5/R7 random", up, dn, md, c, w, wd);
    end
    finish_run();
  end
endmodule